// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a watchdog timer that escalates in two stages. Software sets a tick scale, two tick counts and a reset kind in a control register, then sets the enable bit. A free-running prescaler produces ticks. The first stage counts its ticks and then latches a status flag that drives an interrupt line. The second stage starts in the same cycle and counts its own ticks. When it ends, it latches a second flag and raises one of three reset-request lines. Software holds the timer off by kicking it, which restarts counting at the start of the first stage.

After the first stage has expired, clearing the enable bit no longer stops the timer. This stops a runaway program from silencing the watchdog once the warning interrupt has fired. Access is through a 32-bit register port with a write strobe, a byte address and a combinational read. The byte offsets are 0x0 for the kick register, 0x4 for the status register and 0x8 for the control register.

Top module: `wdt_two_phase`

## Requirements
- R1: After `rst_n` is low, the control register reads 0x00000001 (timer disabled, CPU reset kind), the status register reads 0, and `irqOut` and all three request outputs are low.
- R2: One tick lasts 2^(TICK_EXP+S) clock cycles, where S is control bits 30:29. The first stage expires (A+1) ticks after the write that sets control bit 31, where A is control bits 26:22. In that same edge, status bit 31 and `irqOut` go high.
- R3: The second stage begins as the first one ends and expires (B+1) ticks later, where B is control bits 19:15. In that same edge, status bit 30 goes high and the selected request is raised.
- R4: The reset-kind field is control bits 1:0. Value 0 raises `reqChip`, 1 raises `reqCpu`, 2 raises `reqSw` and 3 raises none. A raised request stays high until `rst_n` is low.
- R5: A write to offset 0x0 with bit 31 set restarts the count at the beginning of the first stage. A write to offset 0x0 with bit 31 clear changes nothing.
- R6: While control bit 31 is clear and the first stage has not expired, the prescaler and the stage counter are held at zero. Setting bit 31 again starts a full first stage.
- R7: Once the first stage has expired, clearing control bit 31 does not delay or stop the reset request.
- R8: Writing 1 to status bit 31 or bit 30 clears that flag, and writing 0 leaves it unchanged. `irqOut` always equals status bit 31.
- R9: The control register reads back bits 31, 30:29, 26:22, 19:15 and 1:0 as written, and reads 0 in every other bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| irqOut | output | 1 | First-stage interrupt |
| reqChip | output | 1 | Full-chip reset request |
| reqCpu | output | 1 | CPU-only reset request |
| reqSw | output | 1 | Software reset request |

## Verification
The bench checks the exact expiry edge of both stages, sampling one cycle early and on the edge itself. A design with an off-by-one tick count, or a prescaler of the wrong length, fails these checks. Zero-valued tick counts must still give a one-tick stage, so a design that expires immediately, or wraps to 32 ticks, is caught. The bench disables the timer in the first stage and again in the second. A design that forgets the count when disabled, or lets a disable cancel the second stage, is reported. It also kicks the timer in mid-count, writes the kick register with bit 31 clear, clears each flag on its own, and selects reset kind 3. These cases catch a design that ignores kicks, treats every write as a kick, clears both flags together, or raises a request for the unused code.

// File: rtl/wdt_two_phase_pkg.sv
package wdt_two_phase_pkg;
  localparam int CNT_W  = 5;
  localparam int PS_W   = 2;
  localparam int MODE_W = 2;

  localparam logic [MODE_W-1:0] KIND_CHIP = 2'd0;
  localparam logic [MODE_W-1:0] KIND_CPU  = 2'd1;
  localparam logic [MODE_W-1:0] KIND_SW   = 2'd2;

  typedef enum logic [1:0] {
    ST_WARN = 2'd0,
    ST_BITE = 2'd1,
    ST_DONE = 2'd2
  } stage_e;

  typedef struct packed {
    logic             clear;
    logic             run;
    logic [PS_W-1:0]  prescale;
    logic [CNT_W-1:0] limit;
  } dpCtrl_t;
endpackage

// File: rtl/wdt_two_phase_dp.sv
module wdt_two_phase_dp
  import wdt_two_phase_pkg::*;
#(
  parameter int TICK_EXP = 25
) (
  input  logic    clk,
  input  logic    rst_n,
  input  dpCtrl_t dpCtl,
  output logic    phaseEnd
);
  localparam int PRE_W = TICK_EXP + (1 << PS_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] tickCnt;
  logic [PRE_W:0]   span;
  logic             tickNow;

  always_comb begin
    span    = ({{PRE_W{1'b0}}, 1'b1} << (TICK_EXP + int'(dpCtl.prescale))) - 1'b1;
    tickNow = ({1'b0, preCnt} >= span);
  end

  assign phaseEnd = dpCtl.run && !dpCtl.clear && tickNow && (tickCnt == dpCtl.limit);

  always_ff @(posedge clk) begin
    if (!rst_n || dpCtl.clear) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (dpCtl.run) begin
      if (tickNow) begin
        preCnt  <= '0;
        tickCnt <= (tickCnt == dpCtl.limit) ? '0 : tickCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_two_phase_ctrl.sv
module wdt_two_phase_ctrl
  import wdt_two_phase_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              phaseEnd,
  output dpCtrl_t           dpCtl,
  output logic              irqOut,
  output logic              reqChip,
  output logic              reqCpu,
  output logic              reqSw
);
  localparam logic [ADDR_W-1:0] OFS_KICK = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(4'h8);

  logic              enable;
  logic [PS_W-1:0]   scaleSel;
  logic [CNT_W-1:0]  warnTicks;
  logic [CNT_W-1:0]  biteTicks;
  logic [MODE_W-1:0] kind;
  stage_e            stage;
  logic              warnFlag;
  logic              biteFlag;

  logic kick, wrStat, wrCtrl, warnEnd, biteEnd;
  logic unusedWrBits;

  assign kick    = wrEn && (addr == OFS_KICK) && wrData[31];
  assign wrStat  = wrEn && (addr == OFS_STAT);
  assign wrCtrl  = wrEn && (addr == OFS_CTRL);
  assign warnEnd = !kick && phaseEnd && (stage == ST_WARN);
  assign biteEnd = !kick && phaseEnd && (stage == ST_BITE);
  assign unusedWrBits = ^{wrData[28:27], wrData[21:20], wrData[14:2]};

  always_comb begin
    dpCtl.run      = (enable || stage != ST_WARN) && (stage != ST_DONE);
    dpCtl.clear    = kick || (!enable && stage == ST_WARN);
    dpCtl.prescale = scaleSel;
    dpCtl.limit    = (stage == ST_BITE) ? biteTicks : warnTicks;
  end

  always_comb begin
    case (addr)
      OFS_STAT: rdData = {warnFlag, biteFlag, 30'd0};
      OFS_CTRL: rdData = {enable, scaleSel, 2'd0, warnTicks, 2'd0, biteTicks, 13'd0, kind};
      default:  rdData = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable    <= 1'b0;
      scaleSel  <= '0;
      warnTicks <= '0;
      biteTicks <= '0;
      kind      <= KIND_CPU;
    end else if (wrCtrl) begin
      enable    <= wrData[31];
      scaleSel  <= wrData[30:29];
      warnTicks <= wrData[26:22];
      biteTicks <= wrData[19:15];
      kind      <= wrData[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage    <= ST_WARN;
      warnFlag <= 1'b0;
      biteFlag <= 1'b0;
      reqChip  <= 1'b0;
      reqCpu   <= 1'b0;
      reqSw    <= 1'b0;
    end else begin
      if (kick)         stage <= ST_WARN;
      else if (warnEnd) stage <= ST_BITE;
      else if (biteEnd) stage <= ST_DONE;

      if (warnEnd)                     warnFlag <= 1'b1;
      else if (wrStat && wrData[31])   warnFlag <= 1'b0;
      if (biteEnd)                     biteFlag <= 1'b1;
      else if (wrStat && wrData[30])   biteFlag <= 1'b0;

      if (biteEnd) begin
        if (kind == KIND_CHIP) reqChip <= 1'b1;
        if (kind == KIND_CPU)  reqCpu  <= 1'b1;
        if (kind == KIND_SW)   reqSw   <= 1'b1;
      end
    end
  end

  assign irqOut = warnFlag;

  // Only one kind of reset may ever be requested (R4)
  assert_req_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reqChip, reqCpu, reqSw}));

  // Requests are held until system reset (R4)
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reqChip || reqCpu || reqSw) |=> (reqChip || reqCpu || reqSw));

  // A request only appears together with the second-stage flag (R3)
  assert_req_with_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reqChip || reqCpu || reqSw) |-> biteFlag);

  // The interrupt flag rises only as the second stage begins (R2)
  assert_irq_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warnFlag) |-> (stage == ST_BITE));

  // Without a kick, the second stage cannot fall back to the first (R7)
  assert_no_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_BITE && !kick) |=> (stage != ST_WARN));
endmodule

// File: rtl/wdt_two_phase.sv
module wdt_two_phase
  import wdt_two_phase_pkg::*;
#(
  parameter int TICK_EXP = 25,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              irqOut,
  output logic              reqChip,
  output logic              reqCpu,
  output logic              reqSw
);
  dpCtrl_t dpCtl;
  logic    phaseEnd;

  wdt_two_phase_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .phaseEnd(phaseEnd), .dpCtl(dpCtl), .irqOut(irqOut),
    .reqChip(reqChip), .reqCpu(reqCpu), .reqSw(reqSw)
  );

  wdt_two_phase_dp #(.TICK_EXP(TICK_EXP)) uDp (
    .clk(clk), .rst_n(rst_n), .dpCtl(dpCtl), .phaseEnd(phaseEnd)
  );
endmodule

// File: tb/wdt_two_phase_test.sv
module wdt_two_phase_test;
  localparam int EXP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wrData = 32'd0;
  logic [31:0] rdData;
  logic        irqOut, reqChip, reqCpu, reqSw;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdt_two_phase #(.TICK_EXP(EXP), .ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqOut(irqOut), .reqChip(reqChip), .reqCpu(reqCpu), .reqSw(reqSw)
  );

  function automatic int phaseCycles(int ps, int cnt);
    return (cnt + 1) << (EXP + ps);
  endfunction

  function automatic logic [31:0] ctrlWord(bit en, int ps, int a, int b, int kind);
    return {en, ps[1:0], 2'd0, a[4:0], 2'd0, b[4:0], 13'd0, kind[1:0]};
  endfunction

  function automatic logic [2:0] expReq(int kind, bit fired);
    if (!fired) return 3'b000;
    case (kind)
      0: return 3'b100;
      1: return 3'b010;
      2: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic waitE(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic runCase(string tag, int ps, int a, int b, int kind);
    logic [31:0] v;
    int t1, t2;
    t1 = phaseCycles(ps, a);
    t2 = phaseCycles(ps, b);
    doReset();
    wr(4'h8, ctrlWord(1'b1, ps, a, b, kind));
    waitE(t1 - 1);
    check({tag, " R2 irq before"}, {31'd0, irqOut}, 32'd0);
    waitE(1);
    check({tag, " R2 irq at expiry"}, {31'd0, irqOut}, 32'd1);
    rd(4'h4, v);
    check({tag, " R2 status"}, v, 32'h8000_0000);
    waitE(t2 - 1);
    check({tag, " R3 no req before"}, {29'd0, reqChip, reqCpu, reqSw}, 32'd0);
    waitE(1);
    check({tag, " R3 R4 req at expiry"}, {29'd0, reqChip, reqCpu, reqSw}, {29'd0, expReq(kind, 1'b1)});
    rd(4'h4, v);
    check({tag, " R3 status"}, v, 32'hC000_0000);
    waitE(40);
    check({tag, " R4 req held"}, {29'd0, reqChip, reqCpu, reqSw}, {29'd0, expReq(kind, 1'b1)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int t1, t2;
    void'($urandom(32'd1357));

    // R1 reset state
    doReset();
    rd(4'h8, v); check("R1 ctrl reset", v, 32'h0000_0001);
    rd(4'h4, v); check("R1 status reset", v, 32'd0);
    check("R1 outputs reset", {28'd0, irqOut, reqChip, reqCpu, reqSw}, 32'd0);

    // R9 readback with stray bits set, timer disabled
    wr(4'h8, 32'h7FFF_FFFE);
    rd(4'h8, v); check("R9 readback", v, 32'h7FFF_FFFE & 32'hE7CF_8003);
    rd(4'h0, v); check("R9 kick reg reads zero", v, 32'd0);

    // Directed corners: one-tick phases, longest phases, unused kind
    runCase("min", 0, 0, 0, 2);
    runCase("max", 3, 31, 31, 0);
    runCase("kind3", 1, 2, 3, 3);

    // R4 request cleared only by reset
    doReset();
    check("R4 req cleared by reset", {29'd0, reqChip, reqCpu, reqSw}, 32'd0);

    // R6 disable before first expiry holds the count
    t1 = phaseCycles(0, 3);
    wr(4'h8, ctrlWord(1'b1, 0, 3, 0, 1));
    waitE(10);
    wr(4'h8, ctrlWord(1'b0, 0, 3, 0, 1));
    waitE(100);
    check("R6 no irq while disabled", {31'd0, irqOut}, 32'd0);
    wr(4'h8, ctrlWord(1'b1, 0, 3, 0, 1));
    waitE(t1 - 1);
    check("R6 full phase after re-enable", {31'd0, irqOut}, 32'd0);
    waitE(1);
    check("R6 expiry after re-enable", {31'd0, irqOut}, 32'd1);

    // R7 disable after first expiry is ignored
    doReset();
    t1 = phaseCycles(0, 0);
    t2 = phaseCycles(0, 3);
    wr(4'h8, ctrlWord(1'b1, 0, 0, 3, 1));
    waitE(t1);
    check("R7 irq", {31'd0, irqOut}, 32'd1);
    wr(4'h8, ctrlWord(1'b0, 0, 0, 3, 1));
    waitE(t2 - 2);
    check("R7 req not yet", {31'd0, reqCpu}, 32'd0);
    waitE(1);
    check("R7 req despite disable", {31'd0, reqCpu}, 32'd1);

    // R8 write-one-to-clear, one flag at a time
    wr(4'h4, 32'h4000_0000);
    rd(4'h4, v); check("R8 clear bit30 only", v, 32'h8000_0000);
    check("R8 irq still high", {31'd0, irqOut}, 32'd1);
    wr(4'h4, 32'h0000_0000);
    rd(4'h4, v); check("R8 zero write no effect", v, 32'h8000_0000);
    wr(4'h4, 32'h8000_0000);
    rd(4'h4, v); check("R8 clear bit31", v, 32'd0);
    check("R8 irq follows flag", {31'd0, irqOut}, 32'd0);

    // R5 kick restarts and non-kick write is ignored
    doReset();
    t1 = phaseCycles(0, 7);
    wr(4'h8, ctrlWord(1'b1, 0, 7, 5, 0));
    waitE(10);
    wr(4'h0, 32'h7FFF_FFFF);
    waitE(t1 - 12);
    check("R5 non-kick before expiry", {31'd0, irqOut}, 32'd0);
    waitE(1);
    check("R5 non-kick write ignored", {31'd0, irqOut}, 32'd1);
    doReset();
    wr(4'h8, ctrlWord(1'b1, 0, 7, 5, 0));
    waitE(20);
    wr(4'h0, 32'h8000_0000);
    waitE(t1 - 1);
    check("R5 kick delays expiry", {31'd0, irqOut}, 32'd0);
    waitE(1);
    check("R5 expiry after kick", {31'd0, irqOut}, 32'd1);

    // Random configurations
    for (int i = 0; i < 12; i++) begin
      runCase("rand", int'($urandom % 4), int'($urandom % 32), int'($urandom % 32),
              int'($urandom % 4));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule